// File: doc/BRIEF.md
# Periodic Software Timer with Sticky Interrupt Flags

This block counts down a small reload value once per tick and raises a sticky timer status flag each time the count expires at zero. On expiry the count is refilled from the reload input in the same cycle, so it keeps running and produces a flag once every `reload + 1` ticks. A second sticky flag captures a single-cycle pulse that reports a failed management-register read. The block does not decode the host bus and does not generate the error pulse.

Each flag has its own enable bit. Host software clears a flag by writing 1 to its bit, and writes the two enable bits in the same access. One registered, active-low interrupt line is driven low while any flag is set together with its enable. A hard reset returns all of this state to zero. A soft reset or a stop request only restarts the countdown and leaves the flags and enables as they were.

Top module: `sw_timer_irq`

## Requirements
- R1: When `tick_en` is 1, `restart` conditions are absent and `count_o` is not 0, `count_o` decreases by one on the clock edge. When `tick_en` is 0, `count_o` holds.
- R2: A tick that finds `count_o` at 0 sets `tmr_flag_o` to 1 and loads `count_o` with `reload_val` on the same edge. The flag therefore rises once every `reload_val + 1` ticks, including when `reload_val` is 0 and when it is 63.
- R3: A host write (`host_wr` = 1) with `host_wdata[0]` = 1 clears `tmr_flag_o`. The same write with bit 0 = 0 leaves the flag unchanged.
- R4: An `err_evt` pulse sets `err_flag_o` on the next edge. A host write with `host_wdata[1]` = 1 clears it, and a write with bit 1 = 0 leaves it unchanged.
- R5: When a hardware set and a host clear reach the same flag in the same cycle, the flag ends at 1.
- R6: Every host write loads `tmr_en_o` from `host_wdata[2]` and `err_en_o` from `host_wdata[3]`.
- R7: `irq_n_o` is registered. After each edge it equals the inverse of (`tmr_flag_o` AND `tmr_en_o`) OR (`err_flag_o` AND `err_en_o`), taken from the values held before that edge.
- R8: `soft_rst` or `stop` loads `count_o` with `reload_val`, overrides any tick, and causes no expiry. Neither input changes the flags, the enables or `irq_n_o`.
- R9: `hard_rst`, a synchronous active-high reset, clears both flags and both enables, drives `irq_n_o` to 1 and loads `count_o` with `reload_val`.
- R10: `reload_val` is sampled only at the moment of a load. A change made during a period takes effect at the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous full reset, active high |
| soft_rst | input | 1 | Restarts the countdown, flags kept |
| stop | input | 1 | Restarts the countdown, flags kept |
| tick_en | input | 1 | Prescaled count tick |
| reload_val | input | RELOAD_W | Countdown reload value |
| err_evt | input | 1 | Management read error pulse |
| host_wr | input | 1 | Host write strobe for flags and enables |
| host_wdata | input | 4 | bit0 timer clear, bit1 error clear, bit2 timer enable, bit3 error enable |
| count_o | output | RELOAD_W | Current countdown value |
| tmr_flag_o | output | 1 | Timer status flag |
| err_flag_o | output | 1 | Read error status flag |
| tmr_en_o | output | 1 | Timer interrupt enable |
| err_en_o | output | 1 | Read error interrupt enable |
| irq_n_o | output | 1 | Interrupt, active low, registered |

## Verification
The bench builds the block with its default 6-bit reload width. With this width the longest period, 64 ticks, runs in well under a hundred cycles, and the bench checks both ends of the reload range: 0, where every tick expires, and 63, where the count wraps from the top. Using the full width keeps the corner cases in reach: a hardware set landing in the same cycle as a host clear, a restart arriving on the same cycle as a tick, and a reload change made in the middle of a period.

// File: rtl/sti_pkg.sv
package sti_pkg;
  // Source indices; each source owns clear bit [i] and enable bit [NSRC+i].
  localparam int unsigned SRC_TMR = 0;
  localparam int unsigned SRC_ERR = 1;
  localparam int unsigned NSRC    = 2;
  localparam int unsigned WD_W    = 2 * NSRC;
endpackage

// File: rtl/sti_countdown.sv
module sti_countdown #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         hard_rst,
  input  logic         restart,
  input  logic         tick_en,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero  = (cnt_o == ZERO);
  assign expire_o = tick_en & ~restart & ~hard_rst & at_zero;

  always_ff @(posedge clk) begin
    if (hard_rst || restart) begin
      cnt_o <= reload_val;
    end else if (tick_en) begin
      cnt_o <= at_zero ? reload_val : (cnt_o - ONE);
    end
  end
endmodule

// File: rtl/sti_sticky_flag.sv
module sti_sticky_flag (
  input  logic clk,
  input  logic hard_rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (hard_rst)   flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set outranks clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sti_irq_merge.sv
module sti_irq_merge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         hard_rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq_n_o
);
  always_ff @(posedge clk) begin
    if (hard_rst) irq_n_o <= 1'b1;
    else          irq_n_o <= ~|(flags & enables);
  end
endmodule

// File: rtl/sw_timer_irq.sv
module sw_timer_irq
  import sti_pkg::*;
#(
  parameter int unsigned RELOAD_W = 6
) (
  input  logic                clk,
  input  logic                hard_rst,
  input  logic                soft_rst,
  input  logic                stop,
  input  logic                tick_en,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                err_evt,
  input  logic                host_wr,
  input  logic [WD_W-1:0]     host_wdata,
  output logic [RELOAD_W-1:0] count_o,
  output logic                tmr_flag_o,
  output logic                err_flag_o,
  output logic                tmr_en_o,
  output logic                err_en_o,
  output logic                irq_n_o
);
  logic            expire;
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] flag_v;
  logic [NSRC-1:0] en_q;

  sti_countdown #(.W(RELOAD_W)) u_cnt (
    .clk        (clk),
    .hard_rst   (hard_rst),
    .restart    (soft_rst | stop),
    .tick_en    (tick_en),
    .reload_val (reload_val),
    .cnt_o      (count_o),
    .expire_o   (expire)
  );

  assign set_v[SRC_TMR] = expire;
  assign set_v[SRC_ERR] = err_evt;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign clr_v[i] = host_wr & host_wdata[i];

    sti_sticky_flag u_flag (
      .clk      (clk),
      .hard_rst (hard_rst),
      .set_i    (set_v[i]),
      .clr_i    (clr_v[i]),
      .flag_o   (flag_v[i])
    );

    always_ff @(posedge clk) begin
      if (hard_rst)     en_q[i] <= 1'b0;
      else if (host_wr) en_q[i] <= host_wdata[NSRC + i];
    end
  end

  sti_irq_merge #(.N(NSRC)) u_irq (
    .clk      (clk),
    .hard_rst (hard_rst),
    .flags    (flag_v),
    .enables  (en_q),
    .irq_n_o  (irq_n_o)
  );

  assign tmr_flag_o = flag_v[SRC_TMR];
  assign err_flag_o = flag_v[SRC_ERR];
  assign tmr_en_o   = en_q[SRC_TMR];
  assign err_en_o   = en_q[SRC_ERR];
endmodule

// File: rtl/sti_checker.sv
module sti_checker #(
  parameter int unsigned RELOAD_W = 6
) (
  input logic                clk,
  input logic                hard_rst,
  input logic                soft_rst,
  input logic                stop,
  input logic                tick_en,
  input logic [RELOAD_W-1:0] reload_val,
  input logic                err_evt,
  input logic                host_wr,
  input logic [3:0]          host_wdata,
  input logic [RELOAD_W-1:0] count_o,
  input logic                tmr_flag_o,
  input logic                err_flag_o,
  input logic                tmr_en_o,
  input logic                err_en_o,
  input logic                irq_n_o
);
  logic restart;
  assign restart = soft_rst | stop;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (hard_rst)
    (tick_en && !restart && count_o != '0) |=> count_o == $past(count_o) - 1'b1);

  assert_expire_sets_R2: assert property (@(posedge clk) disable iff (hard_rst)
    (tick_en && !restart && count_o == '0) |=> (tmr_flag_o && count_o == $past(reload_val)));

  assert_tmr_w1c_R3: assert property (@(posedge clk) disable iff (hard_rst)
    (host_wr && host_wdata[0] && !(tick_en && !restart && count_o == '0)) |=> !tmr_flag_o);

  assert_err_set_R4: assert property (@(posedge clk) disable iff (hard_rst)
    err_evt |=> err_flag_o);

  assert_irq_track_R7: assert property (@(posedge clk) disable iff (hard_rst)
    1'b1 |=> irq_n_o == !(($past(tmr_flag_o) && $past(tmr_en_o)) ||
                          ($past(err_flag_o) && $past(err_en_o))));

  assert_restart_keeps_R8: assert property (@(posedge clk) disable iff (hard_rst)
    (restart && !host_wr && !err_evt) |=>
      ($stable(tmr_flag_o) && $stable(err_flag_o) && count_o == $past(reload_val)));

  assert_hard_reset_R9: assert property (@(posedge clk)
    hard_rst |=> (!tmr_flag_o && !err_flag_o && !tmr_en_o && !err_en_o && irq_n_o));
endmodule

bind sw_timer_irq sti_checker #(.RELOAD_W(RELOAD_W)) u_sti_chk (
  .clk        (clk),
  .hard_rst   (hard_rst),
  .soft_rst   (soft_rst),
  .stop       (stop),
  .tick_en    (tick_en),
  .reload_val (reload_val),
  .err_evt    (err_evt),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .count_o    (count_o),
  .tmr_flag_o (tmr_flag_o),
  .err_flag_o (err_flag_o),
  .tmr_en_o   (tmr_en_o),
  .err_en_o   (err_en_o),
  .irq_n_o    (irq_n_o)
);

// File: tb/test_sw_timer_irq.sv
module test_sw_timer_irq;
  localparam int RW = 6;
  localparam int NV = 21;
  // {tick, evt, wr, wdata[3:0], exp_cnt[5:0], exp_tflag, exp_eflag, exp_irq_n}
  localparam logic [15:0] VEC [NV] = '{
    16'b1_0_0_0000_000001_0_0_1,
    16'b1_0_0_0000_000000_0_0_1,
    16'b1_0_0_0000_000010_1_0_1,
    16'b0_0_1_0100_000010_1_0_1,
    16'b0_0_0_0000_000010_1_0_0,
    16'b0_0_1_0101_000010_0_0_0,
    16'b0_0_0_0000_000010_0_0_1,
    16'b0_1_0_0000_000010_0_1_1,
    16'b0_0_0_0000_000010_0_1_1,
    16'b0_0_1_1100_000010_0_1_1,
    16'b0_0_0_0000_000010_0_1_0,
    16'b0_1_1_1110_000010_0_1_0,
    16'b0_0_1_1100_000010_0_1_0,
    16'b0_0_1_1110_000010_0_0_0,
    16'b0_0_0_0000_000010_0_0_1,
    16'b1_0_0_0000_000001_0_0_1,
    16'b1_0_0_0000_000000_0_0_1,
    16'b1_0_1_1101_000010_1_0_1,
    16'b0_0_0_0000_000010_1_0_0,
    16'b0_0_1_0001_000010_0_0_0,
    16'b0_0_0_0000_000010_0_0_1
  };

  logic          clk = 1'b0;
  logic          hard_rst = 1'b1, soft_rst = 1'b0, stop = 1'b0, tick_en = 1'b0;
  logic [RW-1:0] reload_val = 6'd2;
  logic          err_evt = 1'b0, host_wr = 1'b0;
  logic [3:0]    host_wdata = 4'd0;
  logic [RW-1:0] count_o;
  logic          tmr_flag_o, err_flag_o, tmr_en_o, err_en_o, irq_n_o;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  sw_timer_irq #(.RELOAD_W(RW)) i_sw_timer_irq (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .stop(stop),
    .tick_en(tick_en), .reload_val(reload_val), .err_evt(err_evt),
    .host_wr(host_wr), .host_wdata(host_wdata), .count_o(count_o),
    .tmr_flag_o(tmr_flag_o), .err_flag_o(err_flag_o), .tmr_en_o(tmr_en_o),
    .err_en_o(err_en_o), .irq_n_o(irq_n_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive inputs for one cycle, then sample 5 ns after the edge.
  task automatic step(input logic t, input logic e, input logic w, input logic [3:0] d);
    @(negedge clk);
    tick_en = t; err_evt = e; host_wr = w; host_wdata = d;
    @(posedge clk); #5;
    tick_en = 0; err_evt = 0; host_wr = 0; host_wdata = 0;
  endtask

  task automatic do_hard_reset();
    @(negedge clk); hard_rst = 1;
    @(posedge clk); #5; hard_rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk); #5;
    hard_rst = 0;
    // R9: reset state
    check("R9", "count", int'(count_o), 2);
    check("R9", "flags", int'({tmr_flag_o, err_flag_o, tmr_en_o, err_en_o}), 0);
    check("R9", "irq_n", int'(irq_n_o), 1);

    // R1 R2 R3 R4 R5 R6 R7: vector table
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12:9]);
      check("R1/R2", $sformatf("v%0d count", v), int'(count_o), int'(VEC[v][8:3]));
      check("R2/R3/R5", $sformatf("v%0d tmr_flag", v), int'(tmr_flag_o), int'(VEC[v][2]));
      check("R4/R5", $sformatf("v%0d err_flag", v), int'(err_flag_o), int'(VEC[v][1]));
      check("R7", $sformatf("v%0d irq_n", v), int'(irq_n_o), int'(VEC[v][0]));
    end

    // R6: enables load from bits 2 and 3
    step(0, 0, 1, 4'b1000);
    check("R6", "tmr_en", int'(tmr_en_o), 0);
    check("R6", "err_en", int'(err_en_o), 1);

    // R8: soft reset and stop restart the count and keep flags and enables
    step(0, 0, 1, 4'b1100);
    step(0, 1, 0, 4'b0000);
    step(1, 0, 0, 4'b0000);
    check("R8", "count before restart", int'(count_o), 1);
    @(negedge clk); soft_rst = 1; tick_en = 1;
    @(posedge clk); #5; soft_rst = 0; tick_en = 0;
    check("R8", "soft count", int'(count_o), 2);
    check("R8", "soft err_flag", int'(err_flag_o), 1);
    check("R8", "soft enables", int'({tmr_en_o, err_en_o}), 3);
    check("R8", "soft irq_n", int'(irq_n_o), 0);
    step(1, 0, 0, 4'b0000);
    step(1, 0, 0, 4'b0000);
    @(negedge clk); stop = 1; tick_en = 1;   // count is 0: the tick must not expire
    @(posedge clk); #5; stop = 0; tick_en = 0;
    check("R8", "stop count", int'(count_o), 2);
    check("R8", "stop tmr_flag", int'(tmr_flag_o), 0);
    check("R8", "stop err_flag", int'(err_flag_o), 1);

    // R9: hard reset clears flags and enables
    do_hard_reset();
    check("R9", "flags after reset", int'({tmr_flag_o, err_flag_o, tmr_en_o, err_en_o}), 0);
    check("R9", "irq_n after reset", int'(irq_n_o), 1);
    check("R9", "count after reset", int'(count_o), 2);

    // R2 boundary: reload 0 expires on every tick
    reload_val = 6'd0;
    do_hard_reset();
    step(1, 0, 0, 4'b0000);
    check("R2", "reload0 flag", int'(tmr_flag_o), 1);
    check("R2", "reload0 count", int'(count_o), 0);
    step(1, 0, 1, 4'b0001);
    check("R5", "reload0 set beats clear", int'(tmr_flag_o), 1);

    // R2 and R10: reload 63 wraps from the top; a mid-period change applies at the next load
    reload_val = 6'd63;
    do_hard_reset();
    check("R2", "reload63 start", int'(count_o), 63);
    for (int k = 0; k < 63; k++) step(1, 0, 0, 4'b0000);
    check("R2", "reload63 no early flag", int'(tmr_flag_o), 0);
    check("R1", "reload63 reached zero", int'(count_o), 0);
    reload_val = 6'd5;
    step(0, 0, 0, 4'b0000);
    check("R10", "count held until load", int'(count_o), 0);
    step(1, 0, 0, 4'b0000);
    check("R2", "flag on 64th tick", int'(tmr_flag_o), 1);
    check("R10", "new reload taken", int'(count_o), 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule